// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block holds the control state for one bank of general-purpose pins, split into a number of ports (four by default) of eight pins each. Every port owns three writable registers: a function-select register that claims the pin for plain GPIO use, a direction register, and an output-value register. A fourth, read-only register returns the pin levels after a two-flop synchroniser. All of them sit behind a simple single-cycle memory-mapped read/write bus.

Each writable register has a second, masked address. A write there carries a bit mask in the upper byte of the data and new bit values in the lower byte, so software can change a single pin without first reading the register. A pin is actively driven only while its function-select bit and its direction bit are both set. Otherwise its enable output is low and the pad can be treated as high impedance.

Top module: `gpio_mw_bank`

## Requirements
- R1: While reset is low at a clock edge, every function-select, direction and output-value bit is cleared, so pin_out and pin_oe are all zero after that edge.
- R2: A plain write to offset 0x00 (function select), 0x10 (direction) or 0x20 (output value), plus 4 times the port index, loads wdata[7:0] into that port's register at the clock edge. The other ports and the other registers keep their values.
- R3: A write to the same register address with 0x80 added (the masked alias) changes pin n of the port to wdata[n] only where wdata[8+n] is 1. The bits whose mask bit is 0 keep their values.
- R4: pin_oe for pin n of port p (bit 8p+n) is 1 exactly when both the function-select bit and the direction bit of that pin are 1.
- R5: pin_out bit 8p+n equals the output-value register bit n of port p, whatever the direction.
- R6: A read of offset 0x30 plus 4 times the port index returns that port's pin_in byte as it stood two clock edges earlier, whatever the direction and function-select settings.
- R7: A read of a masked alias address (0x80, 0x90 or 0xA0, plus 4 times the port index) returns the value of the plain register.
- R8: Writes to the input register, to 0xB0 plus 4 times the port index, to any misaligned address (addr[1:0] not 00) or to any other unmapped address leave all registers and pins unchanged.
- R9: A read request updates rdata at the next clock edge, and rdata holds that value until the next read. rdata[31:8] is always 0, and a read of an unmapped or misaligned address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data; for masked writes [15:8] is the mask and [7:0] the values |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin drive enables |

## Verification
The checker assumes that bus_sel, bus_wr, bus_addr and bus_wdata are stable across each rising edge. It also assumes that the bus carries at most one access per cycle, whose effect is judged in the following cycle. The bench changes every input on the falling edge and holds each request for exactly one cycle. Its reads of pin_in wait out the two synchroniser stages before comparing. The pin_in changes are made only while no input-register read is in flight, so synchroniser timing decides each expected read value.

// File: rtl/gpio_mw_pkg.sv
// Shared definitions for the masked-write GPIO bank.
// Assumes the register groups are spaced 0x10 apart with ports 4 bytes apart.
package gpio_mw_pkg;

    // Register group selected by an access.
    typedef enum logic [2:0] {
        GRP_CNF  = 3'd0,
        GRP_OE   = 3'd1,
        GRP_OUT  = 3'd2,
        GRP_IN   = 3'd3,
        GRP_NONE = 3'd4
    } grp_e;

    // Number of writable register kinds per port.
    localparam int NUM_WREGS = 3;

    // Apply a plain or masked write to an old register value.
    function automatic logic [7:0] apply_write(input logic [7:0] old_val,
                                               input logic [15:0] wd,
                                               input logic masked);
        logic [7:0] m;
        m = wd[15:8];
        if (masked)
            apply_write = (old_val & ~m) | (wd[7:0] & m);
        else
            apply_write = wd[7:0];
    endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
// Address decoder: splits a byte address into register group, port index
// and the masked-alias flag. Assumes MASK_OFS is a single power of two
// above the plain register range (0x00..0x3F).
module gpio_mw_decode
    import gpio_mw_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int PORTS    = 4,
    parameter int MASK_OFS = 'h80,
    localparam int PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output grp_e              grp,
    output logic              masked,
    output logic [PORT_W-1:0] port
);

    localparam logic [ADDR_W-1:0] MASK_BITS = ADDR_W'(MASK_OFS);

    logic [ADDR_W-1:0] base;
    logic              in_range;
    logic [1:0]        grp_idx;
    logic [1:0]        port_raw;

    // Strip the alias bit and pick out the fields.
    always_comb begin
        base     = addr & ~MASK_BITS;
        masked   = |(addr & MASK_BITS);
        grp_idx  = base[5:4];
        port_raw = base[3:2];
        port     = PORT_W'(port_raw);
        in_range = (base[1:0] == 2'b00) && ((base >> 6) == '0) &&
                   (int'(port_raw) < PORTS);
    end

    // Map the group index to a register kind; the input has no alias.
    always_comb begin
        grp = GRP_NONE;
        if (in_range) begin
            case (grp_idx)
                2'd0:    grp = GRP_CNF;
                2'd1:    grp = GRP_OE;
                2'd2:    grp = GRP_OUT;
                default: grp = masked ? GRP_NONE : GRP_IN;
            endcase
        end
    end

endmodule

// File: rtl/gpio_mw_sync.sv
// Two-flop synchroniser, one chain per bit. Assumes each input bit is
// independent; no multi-bit coherency is offered.
module gpio_mw_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift each bit one stage down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_mw_port.sv
// Register trio of one port: function select, direction and output value.
// Each register takes plain or masked writes. Assumes at most one
// write strobe is active per cycle.
module gpio_mw_port
    import gpio_mw_pkg::*;
#(
    parameter int PPP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WREGS-1:0] wr_en,
    input  logic                 masked,
    input  logic [2*PPP-1:0]     wdata,
    output logic [PPP-1:0]       cnf,
    output logic [PPP-1:0]       oe,
    output logic [PPP-1:0]       out
);

    logic [PPP-1:0] regs [NUM_WREGS];

    genvar r;
    generate
        for (r = 0; r < NUM_WREGS; r++) begin : g_reg
            // Update one register on its strobe, clearing it in reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[r] <= '0;
                else if (wr_en[r])
                    regs[r] <= PPP'(apply_write(8'(regs[r]), 16'(wdata), masked));
            end
        end
    endgenerate

    assign cnf = regs[0];
    assign oe  = regs[1];
    assign out = regs[2];

endmodule

// File: rtl/gpio_mw_bank.sv
// One GPIO bank: bus decode, per-port register trios, input synchroniser
// and a registered read mux. Assumes one bus access per cycle with
// inputs stable across the clock edge.
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int PORTS    = 4,
    parameter int PPP      = 8,
    parameter int MASK_OFS = 'h80,
    localparam int PINS    = PORTS * PPP,
    localparam int PORT_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    grp_e              dec_grp;
    logic              dec_masked;
    logic [PORT_W-1:0] dec_port;
    logic [PINS-1:0]   in_sync;
    logic [PPP-1:0]    cnf_q [PORTS];
    logic [PPP-1:0]    oe_q  [PORTS];
    logic [PPP-1:0]    out_q [PORTS];
    logic [PPP-1:0]    rd_byte;

    gpio_mw_decode #(
        .ADDR_W   (ADDR_W),
        .PORTS    (PORTS),
        .MASK_OFS (MASK_OFS)
    ) i_decode (
        .addr   (bus_addr),
        .grp    (dec_grp),
        .masked (dec_masked),
        .port   (dec_port)
    );

    gpio_mw_sync #(
        .W      (PINS),
        .STAGES (2)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync)
    );

    genvar p;
    generate
        for (p = 0; p < PORTS; p++) begin : g_port
            logic [NUM_WREGS-1:0] wr_en;
            logic                 sel_here;

            // Raise the write strobe of the addressed register in this port.
            always_comb begin
                sel_here = bus_sel && bus_wr && (int'(dec_port) == p);
                wr_en[0] = sel_here && (dec_grp == GRP_CNF);
                wr_en[1] = sel_here && (dec_grp == GRP_OE);
                wr_en[2] = sel_here && (dec_grp == GRP_OUT);
            end

            gpio_mw_port #(
                .PPP (PPP)
            ) i_port (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (wr_en),
                .masked (dec_masked),
                .wdata  (bus_wdata[2*PPP-1:0]),
                .cnf    (cnf_q[p]),
                .oe     (oe_q[p]),
                .out    (out_q[p])
            );

            assign pin_out[p*PPP +: PPP] = out_q[p];
            assign pin_oe[p*PPP +: PPP]  = cnf_q[p] & oe_q[p];
        end
    endgenerate

    // Select the byte addressed by the current read.
    always_comb begin
        case (dec_grp)
            GRP_CNF: rd_byte = cnf_q[dec_port];
            GRP_OE:  rd_byte = oe_q[dec_port];
            GRP_OUT: rd_byte = out_q[dec_port];
            GRP_IN:  rd_byte = in_sync[dec_port*PPP +: PPP];
            default: rd_byte = '0;
        endcase
    end

    // Capture read data on a read request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_sel && !bus_wr)
            bus_rdata <= DATA_W'(rd_byte);
    end

endmodule

// File: rtl/gpio_mw_bank_chk.sv
// Checker for gpio_mw_bank: tracks the previous bus access and checks pin
// effects one cycle later. Assumes one access per cycle.
module gpio_mw_bank_chk #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int PORTS    = 4,
    parameter int PPP      = 8,
    parameter int MASK_OFS = 'h80,
    localparam int PINS    = PORTS * PPP
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PINS-1:0]   pin_out,
    input logic [PINS-1:0]   pin_oe
);

    logic [ADDR_W-1:0] a_base;
    logic              a_msk, a_ok, a_wr;
    logic [1:0]        a_grp;
    int                a_port;

    // Independent view of which register the current access hits.
    always_comb begin
        a_base = bus_addr & ~ADDR_W'(MASK_OFS);
        a_msk  = (bus_addr & ADDR_W'(MASK_OFS)) != '0;
        a_grp  = a_base[5:4];
        a_port = int'(a_base[3:2]);
        a_ok   = (a_base[1:0] == 2'b00) && (a_base < ADDR_W'('h40)) && (a_port < PORTS);
        a_wr   = bus_sel && bus_wr;
    end

    logic            c_plain_out, c_mask_out, c_zero_cnf, c_no_effect;
    int              c_port;
    logic [15:0]     c_data;
    logic [PPP-1:0]  c_prev_byte;
    logic [PINS-1:0] c_prev_out, c_prev_oe;

    // Remember last cycle's access and pin state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_plain_out <= 1'b0;
            c_mask_out  <= 1'b0;
            c_zero_cnf  <= 1'b0;
            c_no_effect <= 1'b0;
            c_port      <= 0;
            c_data      <= '0;
            c_prev_byte <= '0;
            c_prev_out  <= '0;
            c_prev_oe   <= '0;
        end else begin
            c_plain_out <= a_wr && a_ok && (a_grp == 2'd2) && !a_msk;
            c_mask_out  <= a_wr && a_ok && (a_grp == 2'd2) && a_msk;
            c_zero_cnf  <= a_wr && a_ok && (a_grp == 2'd0) && !a_msk && (bus_wdata[7:0] == 8'h00);
            c_no_effect <= !a_wr || !a_ok || (a_grp == 2'd3);
            c_port      <= (a_port < PORTS) ? a_port : 0;
            c_data      <= bus_wdata[15:0];
            c_prev_byte <= pin_out[((a_port < PORTS) ? a_port : 0)*PPP +: PPP];
            c_prev_out  <= pin_out;
            c_prev_oe   <= pin_oe;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0));

    assert_plain_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_plain_out |-> (pin_out[c_port*PPP +: PPP] == c_data[PPP-1:0]));

    assert_masked_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask_out |-> ((((pin_out[c_port*PPP +: PPP] ^ c_prev_byte) & ~c_data[15:8]) == '0) &&
                        (((pin_out[c_port*PPP +: PPP] ^ c_data[7:0]) & c_data[15:8]) == '0)));

    assert_oe_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_zero_cnf |-> (pin_oe[c_port*PPP +: PPP] == '0));

    assert_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_no_effect |-> (pin_out == c_prev_out && pin_oe == c_prev_oe));

    assert_rdata_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PPP] == '0);

endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PORTS    (PORTS),
    .PPP      (PPP),
    .MASK_OFS (MASK_OFS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_gpio_mw_bank.sv
// Directed bench for gpio_mw_bank: one task per scenario.
module test_gpio_mw_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_mw_bank i_gpio_mw_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 pin_oe", pin_oe, 32'h0);
        for (int p = 0; p < 4; p++) begin
            bus_read(8'(p*4), v);        check("R1 cnf", v, 0);
            bus_read(8'(8'h10 + p*4), v); check("R1 oe", v, 0);
            bus_read(8'(8'h20 + p*4), v); check("R1 out", v, 0);
        end
    endtask

    task automatic t_plain;
        logic [31:0] v;
        bus_write(8'h24, 32'hFFFF_FFA5);
        bus_write(8'h08, 32'h0000_003C);
        bus_read(8'h24, v); check("R2 out p1", v, 32'hA5);
        bus_read(8'h08, v); check("R2 cnf p2", v, 32'h3C);
        bus_read(8'h20, v); check("R2 out p0 untouched", v, 0);
        bus_read(8'h04, v); check("R2 cnf p1 untouched", v, 0);
        check("R5 pin_out", pin_out, 32'h0000_A500);
        check("R4 no oe yet", pin_oe, 32'h0);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        bus_write(8'hA4, 32'h0000_0F0A);
        bus_read(8'h24, v); check("R3 masked low nibble", v, 32'hAA);
        bus_write(8'hA4, 32'h0000_00FF);
        bus_read(8'h24, v); check("R3 empty mask", v, 32'hAA);
        bus_write(8'hAC, 32'h0000_8080);
        check("R3 masked single bit p3", pin_out, 32'h8000_AA00);
        check("R5 pin_out follows", pin_out[15:8], 32'hAA);
    endtask

    task automatic t_gate;
        bus_write(8'h10, 32'h0F);
        bus_write(8'h00, 32'h33);
        check("R4 oe and cnf", pin_oe, 32'h0000_0003);
        bus_write(8'h80, 32'h0000_FFFF);
        check("R4 cnf all", pin_oe, 32'h0000_000F);
        bus_write(8'h98, 32'h0000_0101);
        check("R4 cnf p2 bit0 off", pin_oe, 32'h0000_000F);
        bus_write(8'h98, 32'h0000_0404);
        check("R4 p2 bit2", pin_oe, 32'h0004_000F);
    endtask

    task automatic t_input;
        logic [31:0] v;
        @(negedge clk);
        pin_in = 32'h1234_5678;
        bus_read(8'h30, v); check("R6 latency old value", v, 32'h00);
        bus_read(8'h30, v); check("R6 p0 driven pin", v, 32'h78);
        bus_read(8'h3C, v); check("R6 p3", v, 32'h12);
        bus_read(8'h34, v); check("R6 p1", v, 32'h56);
    endtask

    task automatic t_alias;
        logic [31:0] v;
        bus_read(8'hA4, v); check("R7 masked out alias", v, 32'hAA);
        bus_read(8'h80, v); check("R7 masked cnf alias", v, 32'hFF);
        bus_read(8'h90, v); check("R7 masked oe alias", v, 32'h0F);
        bus_read(8'hB0, v); check("R9 no input alias", v, 0);
        bus_read(8'h21, v); check("R9 misaligned", v, 0);
        bus_read(8'h44, v); check("R9 unmapped", v, 0);
    endtask

    task automatic t_ignore;
        logic [31:0] v;
        logic [31:0] po, pe;
        po = pin_out; pe = pin_oe;
        bus_write(8'h30, 32'h0000_FFFF);
        bus_write(8'hB4, 32'h0000_FF00);
        bus_write(8'h26, 32'h0000_FF00);
        bus_write(8'h44, 32'h0000_FF00);
        check("R8 pin_out held", pin_out, po);
        check("R8 pin_oe held", pin_oe, pe);
        bus_read(8'h30, v); check("R8 input unchanged", v, 32'h78);
        bus_read(8'h24, v); check("R8 out p1 unchanged", v, 32'hAA);
        // hold: no read since, rdata keeps last value
        repeat (3) @(negedge clk);
        check("R9 rdata held", bus_rdata, 32'hAA);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_plain();
                t_masked();
                t_gate();
                t_input();
                t_alias();
                t_ignore();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule